// File: doc/BRIEF.md
# Pipelined Sine and Cosine Generator

This block turns a binary phase angle into a pair of signed sine and cosine samples. The phase is a 24-bit unsigned word that spans one full turn, so 0x000000 is 0 degrees, 0x400000 is 90 degrees, and incrementing past 0xFFFFFF wraps back to 0 degrees. The block rotates a unit vector by shift-and-add micro-rotations that are steered by a small constant table of arctangent steps. It has no multiplier. The top two phase bits select the quadrant. The lower bits are rotated inside the first quadrant, and the result is then mapped back by swapping and negating. The starting vector is preloaded with the inverse of the rotation gain, so the outputs come out at full scale directly.

Each micro-rotation has its own register stage, and one more register stage handles rounding, clamping and the quadrant fix. A new phase can therefore enter on every clock, and results leave in the order the phases entered.

Both edges of the block use valid/ready handshakes. A phase transfers when `in_valid` and `in_ready` are both high at a rising edge. A result transfers when `out_valid` and `out_ready` are both high. The pipeline advances only when its output register is empty or being drained. While a result waits with `out_ready` low, the whole pipeline freezes and `in_ready` is low.

Top module: `sincos_pipe`

## Requirements
- R1: For any phase p, the result transferred for p is round(32767*sin(2*pi*p/2^24)) on `out_sin` and round(32767*cos(2*pi*p/2^24)) on `out_cos`, each within 4 LSB, in 16-bit two's complement.
- R2: With `out_ready` held high, the result for a phase accepted at a rising edge appears with `out_valid` high exactly 17 rising edges later (16 rotation stages plus one output stage).
- R3: Phases presented back to back on consecutive cycles with `out_ready` high are all accepted, and their results come out in order on consecutive cycles.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sin` and `out_cos` hold their values on the next cycle. `out_valid` falls only after a cycle in which `out_ready` was high.
- R5: `in_ready` is high whenever `out_valid` is low or `out_ready` is high, and low otherwise.
- R6: The quadrant and wrap corners hold: 0x000000 gives (0, 32767), 0x400000 gives (32767, 0), 0x800000 gives (0, -32767), 0xC00000 gives (-32767, 0), and 0xFFFFFF gives (0, 32767), each within R1's tolerance, as (sin, cos).
- R7: Outputs are clamped to the range -32767 to 32767, so -32768 never appears while `out_valid` is high.
- R8: A synchronous reset (`rst` high at a rising edge) empties the pipeline. `out_valid` is low on the following cycle and stays low until a phase accepted after reset reaches the output.
- R9: A cycle with `in_valid` low inserts a bubble. Exactly one result is produced for each accepted phase, and nothing is produced for idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the valid chain |
| in_valid | input | 1 | A phase is offered on `in_phase` |
| in_ready | output | 1 | The pipeline can take a phase this cycle |
| in_phase | input | 24 | Unsigned phase, full word range equals one turn |
| out_valid | output | 1 | A result is present on `out_sin` / `out_cos` |
| out_ready | input | 1 | The consumer takes the present result |
| out_sin | output | 16 | Signed sine, full scale 32767 |
| out_cos | output | 16 | Signed cosine, full scale 32767 |

## Verification
Assertions check on every cycle that a stalled result holds steady and that results leave only when taken. They also check that no output reaches -32768, that the residual angle in every stage stays inside a quarter turn, and that the residual left after the last stage is close to zero. The valid chain is checked to empty after reset. Only the bench scenarios can show the numerical accuracy against a real-valued reference, the exact 17-cycle latency, the quadrant and wrap corners, the in-order delivery across bubbles and back-pressure, and the handshake level of `in_ready`.

// File: rtl/sincos_pkg.sv
package sincos_pkg;
  // Internal angle scale: one full turn equals 2**ANG_W.
  localparam int ANG_W = 26;
  localparam int Z_W   = ANG_W + 1;
  // Inverse rotation gain, 0.607252935 in Q30.
  localparam longint INV_GAIN_Q30 = 64'sd652032874;

  // atan(2**-i) expressed in units of one turn / 2**ANG_W.
  function automatic logic [ANG_W-1:0] atan_step(input int i);
    case (i)
      0:  return 26'd8388608;
      1:  return 26'd4952085;
      2:  return 26'd2616545;
      3:  return 26'd1328199;
      4:  return 26'd666677;
      5:  return 26'd333664;
      6:  return 26'd166872;
      7:  return 26'd83441;
      8:  return 26'd41721;
      9:  return 26'd20861;
      10: return 26'd10430;
      11: return 26'd5215;
      12: return 26'd2608;
      13: return 26'd1304;
      14: return 26'd652;
      15: return 26'd326;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sincos_stage.sv
module sincos_stage
  import sincos_pkg::*;
#(
  parameter int XW    = 21,
  parameter int SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 in_v,
  input  logic signed [XW-1:0] in_x,
  input  logic signed [XW-1:0] in_y,
  input  logic signed [Z_W-1:0] in_z,
  input  logic [1:0]           in_q,
  output logic                 out_v,
  output logic signed [XW-1:0] out_x,
  output logic signed [XW-1:0] out_y,
  output logic signed [Z_W-1:0] out_z,
  output logic [1:0]           out_q
);
  localparam logic signed [Z_W-1:0] STEP = $signed(Z_W'(atan_step(SHIFT)));
  localparam logic signed [Z_W-1:0] QTURN = $signed(Z_W'(1) <<< (ANG_W - 2));

  logic                  turn_up;
  logic signed [XW-1:0]  x_sh, y_sh, nx, ny;
  logic signed [Z_W-1:0] nz;

  always_comb begin
    turn_up = !in_z[Z_W-1];
    x_sh    = in_x >>> SHIFT;
    y_sh    = in_y >>> SHIFT;
    nx      = turn_up ? in_x - y_sh : in_x + y_sh;
    ny      = turn_up ? in_y + x_sh : in_y - x_sh;
    nz      = turn_up ? in_z - STEP : in_z + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst)      out_v <= 1'b0;
    else if (adv) out_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_x <= nx;
      out_y <= ny;
      out_z <= nz;
      out_q <= in_q;
    end
  end

  // R1: the residual angle never leaves a quarter turn either side of zero.
  assert_residual_bound_R1: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_z < QTURN && out_z > -QTURN));
endmodule

// File: rtl/sincos_post.sv
module sincos_post #(
  parameter int XW    = 21,
  parameter int OUT_W = 16,
  parameter int GUARD = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    in_v,
  input  logic signed [XW-1:0]    in_x,
  input  logic signed [XW-1:0]    in_y,
  input  logic [1:0]              in_q,
  output logic                    out_v,
  output logic signed [OUT_W-1:0] out_s,
  output logic signed [OUT_W-1:0] out_c
);
  localparam logic signed [XW-1:0] LIM  = XW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [XW-1:0] HALF = XW'(1) <<< (GUARD - 1);
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [XW-1:0]    xr, yr, xc, yc;
  logic signed [OUT_W-1:0] cv, sv, s_n, c_n;

  always_comb begin
    xr = (in_x + HALF) >>> GUARD;
    yr = (in_y + HALF) >>> GUARD;
    xc = (xr > LIM) ? LIM : ((xr < -LIM) ? -LIM : xr);
    yc = (yr > LIM) ? LIM : ((yr < -LIM) ? -LIM : yr);
    cv = xc[OUT_W-1:0];
    sv = yc[OUT_W-1:0];
    case (in_q)
      2'd0: begin s_n = sv;  c_n = cv;  end
      2'd1: begin s_n = cv;  c_n = -sv; end
      2'd2: begin s_n = -sv; c_n = -cv; end
      default: begin s_n = -cv; c_n = sv; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      out_v <= 1'b0;
    else if (adv) out_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_s <= s_n;
      out_c <= c_n;
    end
  end

  // R7: the clamp keeps the most negative code off the outputs.
  assert_no_most_negative_R7: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_s != MOST_NEG && out_c != MOST_NEG));
endmodule

// File: rtl/sincos_pipe.sv
module sincos_pipe
  import sincos_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int OUT_W   = 16,
  parameter int GUARD   = 3,
  parameter int STAGES  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PHASE_W-1:0]      in_phase,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_sin,
  output logic signed [OUT_W-1:0] out_cos
);
  localparam int XW = OUT_W + GUARD + 2;
  localparam int SH = ANG_W - PHASE_W;
  localparam longint FULL = longint'((2 ** (OUT_W - 1)) - 1) <<< GUARD;
  localparam longint X0_L = (FULL * INV_GAIN_Q30 + (64'sd1 <<< 29)) >>> 30;
  localparam logic signed [XW-1:0] X_START = XW'(X0_L);
  localparam int LAST_STEP = (STAGES > 16) ? 15 : STAGES - 1;
  localparam logic signed [Z_W-1:0] Z_DONE = $signed(Z_W'(2 * atan_step(LAST_STEP) + 16));

  logic                  adv;
  logic                  vs [0:STAGES];
  logic signed [XW-1:0]  xs [0:STAGES];
  logic signed [XW-1:0]  ys [0:STAGES];
  logic signed [Z_W-1:0] zs [0:STAGES];
  logic [1:0]            qs [0:STAGES];

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign vs[0] = in_valid;
  assign xs[0] = X_START;
  assign ys[0] = '0;
  assign zs[0] = $signed(Z_W'(in_phase[PHASE_W-3:0]) << SH);
  assign qs[0] = in_phase[PHASE_W-1:PHASE_W-2];

  for (genvar i = 0; i < STAGES; i++) begin : g_rot
    sincos_stage #(.XW(XW), .SHIFT(i)) u_stage (
      .clk(clk), .rst(rst), .adv(adv),
      .in_v(vs[i]), .in_x(xs[i]), .in_y(ys[i]), .in_z(zs[i]), .in_q(qs[i]),
      .out_v(vs[i+1]), .out_x(xs[i+1]), .out_y(ys[i+1]), .out_z(zs[i+1]), .out_q(qs[i+1])
    );
  end

  sincos_post #(.XW(XW), .OUT_W(OUT_W), .GUARD(GUARD)) u_post (
    .clk(clk), .rst(rst), .adv(adv),
    .in_v(vs[STAGES]), .in_x(xs[STAGES]), .in_y(ys[STAGES]), .in_q(qs[STAGES]),
    .out_v(out_valid), .out_s(out_sin), .out_c(out_cos)
  );

  // R4: a stalled result stays put.
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sin) && $stable(out_cos)));

  // R4: a result only leaves after being taken.
  assert_leave_when_taken_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_ready));

  // R8: reset empties the output register.
  assert_reset_empty_R8: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R1: after the last rotation the residual angle has nearly vanished.
  assert_converged_R1: assert property (@(posedge clk) disable iff (rst)
    vs[STAGES] |-> (zs[STAGES] < Z_DONE && zs[STAGES] > -Z_DONE));
endmodule

// File: tb/sincos_pipe_test.sv
module sincos_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int TOL = 4;
  localparam int NVEC = 16;
  localparam real TWO_PI = 6.283185307179586;

  localparam logic [23:0] VEC_PH [NVEC] = '{
    24'h000000, 24'h400000, 24'h800000, 24'hC00000,
    24'h200000, 24'h600000, 24'hA00000, 24'hE00000,
    24'h155555, 24'h2AAAAB, 24'h955555, 24'hD55555,
    24'h3FFFFF, 24'hFFFFFF, 24'h400001, 24'h7FFFFF};
  localparam int VEC_S [NVEC] = '{
    0, 32767, 0, -32767, 23170, 23170, -23170, -23170,
    16384, 28377, -16384, -28377, 32767, 0, 32767, 0};
  localparam int VEC_C [NVEC] = '{
    32767, 0, -32767, 0, 23170, -23170, -23170, 23170,
    28377, 16384, -28377, 16384, 0, 32767, 0, -32767};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [23:0] in_phase = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_sin, out_cos;

  int total = 0;
  int fails = 0;
  int exp_s [0:255];
  int exp_c [0:255];
  string exp_tag [0:255];
  int wr = 0;
  int rd = 0;
  int accepted = 0;
  int produced = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sincos_pipe uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready),
    .out_sin(out_sin), .out_cos(out_cos)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int ref_sin(input logic [23:0] p);
    return int'(32767.0 * $sin(TWO_PI * real'(p) / 16777216.0));
  endfunction
  function automatic int ref_cos(input logic [23:0] p);
    return int'(32767.0 * $cos(TWO_PI * real'(p) / 16777216.0));
  endfunction

  function automatic bit near(input int a, input int b);
    return (a - b <= TOL) && (b - a <= TOL);
  endfunction

  // One cycle: drive inputs at the falling edge, then record both handshakes.
  task automatic step(input logic v, input logic [23:0] ph, input logic rdy,
                      input int es, input int ec, input string tag);
    @(negedge clk);
    in_valid = v; in_phase = ph; out_ready = rdy;
    #1;
    if (!rst && v && in_ready) begin
      exp_s[wr[7:0]] = es; exp_c[wr[7:0]] = ec; exp_tag[wr[7:0]] = tag;
      wr++; accepted++;
    end
    if (!rst && out_valid && out_ready) begin
      chk(near(out_sin, exp_s[rd[7:0]]), {exp_tag[rd[7:0]], " sin"}, out_sin, exp_s[rd[7:0]]);
      chk(near(out_cos, exp_c[rd[7:0]]), {exp_tag[rd[7:0]], " cos"}, out_cos, exp_c[rd[7:0]]);
      rd++; produced++;
    end
  endtask

  task automatic send(input logic [23:0] ph, input logic rdy, input string tag);
    step(1'b1, ph, rdy, ref_sin(ph), ref_cos(ph), tag);
  endtask

  task automatic drain(input int n);
    for (int k = 0; k < n; k++) step(1'b0, '0, 1'b1, 0, 0, "idle");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    int cnt, held_s, held_c, acc0, prod0, wr0;
    logic [23:0] rp;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R5 in_ready idle", in_ready, 1);

    // R2: latency of a single phase
    in_valid = 1'b1; in_phase = 24'h200000; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 1;
    while (!out_valid && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == 17, "R2 latency", cnt, 17);
    chk(near(out_sin, 23170) && near(out_cos, 23170), "R1 single 45deg", out_sin, 23170);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 single phase gives one result", out_valid, 0);

    // R1 R6 R3: vector table streamed back to back
    acc0 = accepted;
    for (int i = 0; i < NVEC; i++)
      step(1'b1, VEC_PH[i], 1'b1, VEC_S[i], VEC_C[i], (i < 4 || i == 13) ? "R6 corner" : "R1 table");
    chk(accepted - acc0 == NVEC, "R3 all accepted back to back", accepted - acc0, NVEC);
    drain(20);
    chk(rd == wr, "R3 all table results out", rd, wr);

    // R1: random phases
    for (int i = 0; i < 40; i++) begin
      rp = 24'($urandom);
      send(rp, 1'b1, "R1 random");
    end
    drain(20);
    chk(rd == wr, "R1 random results out", rd, wr);

    // R9: bubbles between phases
    acc0 = accepted; prod0 = produced;
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 0) send(24'(i * 24'h123457), 1'b1, "R9 bubble");
      else step(1'b0, 24'hABCDEF, 1'b1, 0, 0, "idle");
    end
    drain(20);
    chk(produced - prod0 == accepted - acc0, "R9 one result per accepted phase",
        produced - prod0, accepted - acc0);

    // R4 R5: back-pressure
    for (int i = 0; i < 24; i++) send(24'(24'h0F0F0F + i * 24'h0A0000), 1'b0, "R4 stalled");
    chk(out_valid == 1'b1, "R4 output waiting", out_valid, 1);
    chk(in_ready == 1'b0, "R5 in_ready low when stalled", in_ready, 0);
    held_s = out_sin; held_c = out_cos; wr0 = wr;
    for (int i = 0; i < 3; i++) send(24'h555555, 1'b0, "R4 stalled");
    chk(wr == wr0, "R5 nothing accepted while stalled", wr, wr0);
    chk(out_valid && out_sin == held_s, "R4 sin held", out_sin, held_s);
    chk(out_cos == held_c, "R4 cos held", out_cos, held_c);
    for (int i = 0; i < 30; i++) send(24'(i * 24'h07A3B1), (i % 2) == 1, "R4 toggled ready");
    drain(40);
    chk(rd == wr, "R4 all results after back-pressure", rd, wr);
    chk(in_ready == 1'b1, "R5 in_ready after drain", in_ready, 1);

    // R8: reset in mid-stream
    for (int i = 0; i < 6; i++) send(24'(i * 24'h111111), 1'b1, "R8 pre-reset");
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd = wr;
    prod0 = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (out_valid) prod0++;
    end
    chk(prod0 == 0, "R8 no results after reset", prod0, 0);
    send(24'h400000, 1'b1, "R8 after reset");
    drain(20);
    chk(rd == wr, "R8 fresh phase after reset", rd, wr);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule